// File: doc/BRIEF.md
# Per-source interrupt event gate

This block keeps a two-bit pending/queued state for each of a set of interrupt sources and decides, from that state, whether a new trigger is passed on to the interrupt router. Software and devices reach it through a simple memory-mapped request port. Each source has two pages: a management page and a trigger page. The operation is chosen by which page is addressed, by the offset inside it and by whether the access is a load or a store. The write data never matters, so the request port carries none.

The P bit records that an event has been forwarded and not yet completed. The Q bit records a second trigger that arrived while P was set, so that it can be replayed after end-of-interrupt. The state value 01 is the masked state. Loads return the state the source held before the access, one cycle later. Forwarded events leave as a one-cycle pulse on a per-source vector. A separate hardware trigger input lets a device line or message trigger a source without going through the request port.

Top module: `pq_event_gate`

## Requirements
- R1: After reset every source holds PQ = 01 (masked), `rsp_valid` is low and `fwd_event` is all zero.
- R2: A load to either page of a source, at any offset, raises `rsp_valid` for exactly the next cycle, with `rsp_pq` holding that source's state from before the access (P on bit 1, Q on bit 0). A store never produces a response.
- R3: A trigger is a store to a source's trigger page (any offset) or a pulse on `trig_valid` for that source. It moves 00 to 10 and forwards, 10 to 11, keeps 11 as 11 and keeps 01 as 01. Only the move from 00 forwards.
- R4: A load at management offset 0xC00 moves 11 to 10 and forwards one replayed event. From any other state it moves the source to 00 with no forward.
- R5: A load at management offset 0xD00 moves the source to 01 from any state, with no forward.
- R6: End-of-interrupt is a load at management offset 0x000 or a store at management offset 0x400. It moves 10 to 00 and moves 11 to 10 with one forward. It leaves 00 and 01 unchanged.
- R7: Loads at other management offsets, loads on the trigger page, and stores to the management page at any offset other than 0x400 change no state and forward nothing.
- R8: When a request and a `trig_valid` reach the same source in the same cycle, the request's effect is applied first and the trigger is then applied to the result.
- R9: A forward appears as a one-cycle pulse on bit `i` of `fwd_event`, in the cycle after the access, for source `i` only. Accesses to one source never change another source's state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_trig_page | input | 1 | 1 = trigger page, 0 = management page |
| req_src | input | SRC_W | Source addressed by the request |
| req_offset | input | OFS_W | Byte offset inside the page |
| trig_valid | input | 1 | Hardware trigger present this cycle |
| trig_src | input | SRC_W | Source of the hardware trigger |
| rsp_valid | output | 1 | Load response valid |
| rsp_pq | output | 2 | Previous state of the loaded source |
| fwd_event | output | NUM_SRC | Per-source forwarded-event pulses |

## Verification
A wrong state inside one cell stays hidden until that source is touched again. It then shows up in one of two ways: a load response returns the wrong previous state, or a later trigger or end-of-interrupt forwards when it should not, or fails to forward. The bench keeps its own behavioural model of all sixteen states and compares the response and the whole forward vector after every clock. A divergence is therefore reported in the cycle after the first access that exposes it. The directed sequences expose every state on purpose through query loads, and a long mixed stream revisits each source many times.

// File: rtl/pq_gate_pkg.sv
package pq_gate_pkg;

  typedef logic [1:0] pq_t;

  localparam pq_t PQ_OFF    = 2'b00;
  localparam pq_t PQ_MASKED = 2'b01;
  localparam pq_t PQ_PEND   = 2'b10;
  localparam pq_t PQ_COAL   = 2'b11;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_QUERY,
    OP_EOI,
    OP_SET_OFF,
    OP_SET_MASK,
    OP_TRIG
  } op_e;

  typedef struct packed {
    pq_t  pq;
    logic fwd;
  } step_t;

  // Trigger transition: only an idle source forwards.
  function automatic step_t trig_step(pq_t s);
    step_t r;
    r.pq  = s;
    r.fwd = 1'b0;
    case (s)
      PQ_OFF:  begin r.pq = PQ_PEND; r.fwd = 1'b1; end
      PQ_PEND: r.pq = PQ_COAL;
      default: r.pq = s;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pq_access_decode.sv
module pq_access_decode
  import pq_gate_pkg::*;
#(
  parameter int OFS_W        = 12,
  parameter int LD_EOI_OFS   = 'h000,
  parameter int ST_EOI_OFS   = 'h400,
  parameter int SET_OFF_OFS  = 'hC00,
  parameter int SET_MASK_OFS = 'hD00
) (
  input  logic             req_valid,
  input  logic             req_store,
  input  logic             req_trig_page,
  input  logic [OFS_W-1:0] req_offset,
  output op_e              op
);

  localparam logic [OFS_W-1:0] K_LD_EOI   = OFS_W'(LD_EOI_OFS);
  localparam logic [OFS_W-1:0] K_ST_EOI   = OFS_W'(ST_EOI_OFS);
  localparam logic [OFS_W-1:0] K_SET_OFF  = OFS_W'(SET_OFF_OFS);
  localparam logic [OFS_W-1:0] K_SET_MASK = OFS_W'(SET_MASK_OFS);

  always_comb begin
    op = OP_NONE;
    if (req_valid) begin
      if (req_trig_page) begin
        op = req_store ? OP_TRIG : OP_QUERY;
      end else if (req_store) begin
        op = (req_offset == K_ST_EOI) ? OP_EOI : OP_NONE;
      end else if (req_offset == K_LD_EOI) begin
        op = OP_EOI;
      end else if (req_offset == K_SET_OFF) begin
        op = OP_SET_OFF;
      end else if (req_offset == K_SET_MASK) begin
        op = OP_SET_MASK;
      end else begin
        op = OP_QUERY;
      end
    end
  end

endmodule

// File: rtl/pq_source_cell.sv
module pq_source_cell
  import pq_gate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mmio_hit,
  input  op_e  op,
  input  logic trig_hit,
  output pq_t  pq_o,
  output logic fwd_o
);

  pq_t   pq_q, pq_d, pq_mid;
  logic  fwd_q, fwd_d, fwd_mmio, fwd_trig;
  logic  upd_en;
  step_t s_mmio, s_trig;

  // Request first, then the hardware trigger on the result.
  always_comb begin
    pq_mid   = pq_q;
    fwd_mmio = 1'b0;
    s_mmio   = trig_step(pq_q);
    if (mmio_hit) begin
      case (op)
        OP_EOI: begin
          if (pq_q == PQ_PEND) begin
            pq_mid = PQ_OFF;
          end else if (pq_q == PQ_COAL) begin
            pq_mid   = PQ_PEND;
            fwd_mmio = 1'b1;
          end
        end
        OP_SET_OFF: begin
          if (pq_q == PQ_COAL) begin
            pq_mid   = PQ_PEND;
            fwd_mmio = 1'b1;
          end else begin
            pq_mid = PQ_OFF;
          end
        end
        OP_SET_MASK: pq_mid = PQ_MASKED;
        OP_TRIG: begin
          pq_mid   = s_mmio.pq;
          fwd_mmio = s_mmio.fwd;
        end
        default: pq_mid = pq_q;
      endcase
    end
    s_trig   = trig_step(pq_mid);
    pq_d     = trig_hit ? s_trig.pq : pq_mid;
    fwd_trig = trig_hit & s_trig.fwd;
    fwd_d    = fwd_mmio | fwd_trig;
    upd_en   = mmio_hit | trig_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pq_q  <= PQ_MASKED;
      fwd_q <= 1'b0;
    end else begin
      fwd_q <= fwd_d;
      if (upd_en) begin
        pq_q <= pq_d;
      end
    end
  end

  assign pq_o  = pq_q;
  assign fwd_o = fwd_q;

  // A forward always leaves P set behind it (R3, R9)
  p_fwd_sets_p_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_q |-> pq_q[1]);

  // Masked state is left only through a 0xC00 load (R5)
  p_mask_sticks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pq_q == PQ_MASKED && !(mmio_hit && op == OP_SET_OFF)) |=> pq_q == PQ_MASKED);

  // Coalesced state is left only by a request (R6)
  p_coal_sticks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pq_q == PQ_COAL && !mmio_hit) |=> pq_q == PQ_COAL);

  // First trigger on an idle source forwards (R3)
  p_first_trig_fwd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pq_q == PQ_OFF && trig_hit && !mmio_hit) |=> (fwd_q && pq_q == PQ_PEND));

  // End-of-interrupt replays the queued event (R6)
  p_eoi_replay_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pq_q == PQ_COAL && mmio_hit && op == OP_EOI && !trig_hit) |=> (fwd_q && pq_q == PQ_PEND));

endmodule

// File: rtl/pq_event_gate.sv
module pq_event_gate
  import pq_gate_pkg::*;
#(
  parameter int  NUM_SRC = 16,
  parameter int  OFS_W   = 12,
  localparam int SRC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_store,
  input  logic               req_trig_page,
  input  logic [SRC_W-1:0]   req_src,
  input  logic [OFS_W-1:0]   req_offset,
  input  logic               trig_valid,
  input  logic [SRC_W-1:0]   trig_src,
  output logic               rsp_valid,
  output logic [1:0]         rsp_pq,
  output logic [NUM_SRC-1:0] fwd_event
);

  op_e                op;
  logic [NUM_SRC-1:0] mmio_hit, trig_hit;
  pq_t                pq_vec [NUM_SRC];
  pq_t                sel_pq;
  logic               rsp_v_d, rsp_v_q;
  pq_t                rsp_pq_q;

  pq_access_decode #(.OFS_W(OFS_W)) u_dec (
    .req_valid     (req_valid),
    .req_store     (req_store),
    .req_trig_page (req_trig_page),
    .req_offset    (req_offset),
    .op            (op)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cell
    assign mmio_hit[g] = req_valid && (req_src == SRC_W'(g));
    assign trig_hit[g] = trig_valid && (trig_src == SRC_W'(g));

    pq_source_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .mmio_hit (mmio_hit[g]),
      .op       (op),
      .trig_hit (trig_hit[g]),
      .pq_o     (pq_vec[g]),
      .fwd_o    (fwd_event[g])
    );
  end

  always_comb begin
    sel_pq = PQ_OFF;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req_src == SRC_W'(i)) sel_pq = pq_vec[i];
    end
    rsp_v_d = req_valid && !req_store;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_v_q  <= 1'b0;
      rsp_pq_q <= PQ_OFF;
    end else begin
      rsp_v_q <= rsp_v_d;
      if (rsp_v_d) begin
        rsp_pq_q <= sel_pq;
      end
    end
  end

  assign rsp_valid = rsp_v_q;
  assign rsp_pq    = rsp_pq_q;

  // A response follows only a load (R2)
  p_rsp_after_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_store));

  // Stores are silent on the response side (R2)
  p_store_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store) |=> !rsp_valid);

endmodule

// File: tb/pq_event_gate_test.sv
module pq_event_gate_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int N = 16;

  logic        clk, rst_n;
  logic        req_valid, req_store, req_trig_page;
  logic [3:0]  req_src;
  logic [11:0] req_offset;
  logic        trig_valid;
  logic [3:0]  trig_src;
  logic        rsp_valid;
  logic [1:0]  rsp_pq;
  logic [N-1:0] fwd_event;

  int checks;
  int failures;
  int mpq [N];
  bit done;

  pq_event_gate #(.NUM_SRC(N), .OFS_W(12)) uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_store     (req_store),
    .req_trig_page (req_trig_page),
    .req_src       (req_src),
    .req_offset    (req_offset),
    .trig_valid    (trig_valid),
    .trig_src      (trig_src),
    .rsp_valid     (rsp_valid),
    .rsp_pq        (rsp_pq),
    .fwd_event     (fwd_event)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int trig_next(int s);
    if (s == 0) return 2;
    if (s == 2) return 3;
    return s;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // One cycle of stimulus, model update and comparison.
  task automatic cyc(bit v, bit st, bit tp, int src, int ofs,
                     bit tv, int tsrc, string tag);
    bit          e_rv;
    int          e_rpq;
    logic [N-1:0] e_fwd;
    int          s;
    @(negedge clk);
    req_valid     = v;
    req_store     = st;
    req_trig_page = tp;
    req_src       = 4'(src);
    req_offset    = 12'(ofs);
    trig_valid    = tv;
    trig_src      = 4'(tsrc);
    e_rv  = v && !st;
    e_rpq = mpq[src];
    e_fwd = '0;
    if (v) begin
      s = mpq[src];
      if (tp) begin
        if (st) begin
          if (s == 0) e_fwd[src] = 1'b1;
          s = trig_next(s);
        end
      end else if ((!st && ofs == 'h000) || (st && ofs == 'h400)) begin
        if (s == 2) s = 0;
        else if (s == 3) begin s = 2; e_fwd[src] = 1'b1; end
      end else if (!st && ofs == 'hC00) begin
        if (s == 3) begin s = 2; e_fwd[src] = 1'b1; end
        else s = 0;
      end else if (!st && ofs == 'hD00) begin
        s = 1;
      end
      mpq[src] = s;
    end
    if (tv) begin
      if (mpq[tsrc] == 0) e_fwd[tsrc] = 1'b1;
      mpq[tsrc] = trig_next(mpq[tsrc]);
    end
    @(posedge clk);
    #2;
    check(tag, "rsp_valid", int'(rsp_valid), int'(e_rv));
    if (e_rv) check(tag, "rsp_pq", int'(rsp_pq), e_rpq);
    check(tag, "fwd_event", int'(fwd_event), int'(e_fwd));
  endtask

  task automatic ld(int src, int ofs, string tag);
    cyc(1, 0, 0, src, ofs, 0, 0, tag);
  endtask

  task automatic hw_trig(int src, string tag);
    cyc(0, 0, 0, 0, 0, 1, src, tag);
  endtask

  initial begin
    checks = 0; failures = 0; done = 0;
    for (int i = 0; i < N; i++) mpq[i] = 1;
    rst_n = 1'b0;
    req_valid = 0; req_store = 0; req_trig_page = 0;
    req_src = '0; req_offset = '0; trig_valid = 0; trig_src = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state at the ports
    check("R1", "rsp_valid", int'(rsp_valid), 0);
    check("R1", "fwd_event", int'(fwd_event), 0);
    for (int i = 0; i < N; i++) ld(i, 'h800, "R1");

    // R3 / R4 / R6 on source 2
    ld(2, 'hC00, "R4");
    cyc(1, 1, 1, 2, 'h123, 0, 0, "R3");
    hw_trig(2, "R3");
    hw_trig(2, "R3");
    ld(2, 'h000, "R6");
    cyc(1, 1, 0, 2, 'h400, 0, 0, "R6");
    cyc(1, 1, 0, 2, 'h400, 0, 0, "R6");
    ld(2, 'h800, "R6");

    // R4 replay through 0xC00 on source 5
    ld(5, 'hC00, "R4");
    hw_trig(5, "R3");
    hw_trig(5, "R3");
    ld(5, 'hC00, "R4");
    ld(5, 'hC00, "R4");

    // R5 masking on source 7
    ld(7, 'hC00, "R4");
    hw_trig(7, "R3");
    ld(7, 'hD00, "R5");
    hw_trig(7, "R5");
    cyc(1, 1, 1, 7, 'h0, 0, 0, "R5");
    cyc(1, 1, 0, 7, 'h400, 0, 0, "R6");
    ld(7, 'h000, "R6");
    ld(7, 'h800, "R5");

    // R7 ignored accesses on source 9
    ld(9, 'hC00, "R7");
    cyc(1, 1, 0, 9, 'h000, 0, 0, "R7");
    cyc(1, 1, 0, 9, 'hC00, 0, 0, "R7");
    cyc(1, 1, 0, 9, 'hD00, 0, 0, "R7");
    cyc(1, 0, 1, 9, 'hC00, 0, 0, "R7");
    ld(9, 'h404, "R7");
    ld(9, 'h800, "R7");

    // R8 same-cycle request and trigger on source 11
    cyc(1, 0, 0, 11, 'hD00, 1, 11, "R8");
    cyc(1, 0, 0, 11, 'hC00, 1, 11, "R8");
    cyc(1, 0, 0, 11, 'h000, 1, 11, "R8");
    cyc(1, 1, 1, 11, 'h000, 1, 11, "R8");
    ld(11, 'h800, "R8");

    // R9 two sources forwarding together
    ld(1, 'hC00, "R9");
    ld(4, 'hC00, "R9");
    cyc(1, 1, 1, 1, 'h8, 1, 4, "R9");
    ld(4, 'h800, "R9");

    // R2 mixed stream over all operations
    void'($urandom(32'h5eed));
    for (int k = 0; k < 600; k++) begin
      int pick;
      int ofs;
      pick = $urandom_range(0, 5);
      case (pick)
        0: ofs = 'h000;
        1: ofs = 'h400;
        2: ofs = 'hC00;
        3: ofs = 'hD00;
        4: ofs = 'h800;
        default: ofs = 'h404;
      endcase
      cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
          1'($urandom_range(0, 1)), $urandom_range(0, N - 1), ofs,
          1'($urandom_range(0, 1)), $urandom_range(0, N - 1), "R2");
    end
    for (int i = 0; i < N; i++) ld(i, 'h800, "R2");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule